// File: doc/BRIEF.md
# Upset Sensitivity Lookup Classifier

This block sits behind a configuration-memory scrubber and decides how much an upset matters. Each error report gives a frame number, a bit offset inside the frame and an error kind. The block turns the location into an entry address in a sensitivity map kept in memory outside the block. Each map entry holds a 5-bit region tag for one group of bits. Tag 0 marks bits the design does not use. Tags 1 to 16 mark used regions, and tag 1 is the default for used logic. Any number of design areas may carry the same tag.

Two handling paths exist, chosen per report by a mode input. On the local path the block reads the map entry itself through a request/response memory port. It then presents a critical flag and a region number, marked by a one-cycle valid pulse. On the remote path it reads no memory. Instead it latches the raw report into host-visible outputs and raises an interrupt, which stays up until the host acknowledges it. A single holding slot absorbs a report that arrives while an earlier one is still in progress. A report that finds the slot already occupied is dropped, and a sticky overflow flag records the loss.

Top module: `upset_classifier`

## Requirements
- R1: On the local path, exactly one single-cycle memory request is issued per looked-up report. Its address is frame × WORDS_PER_FRAME + (offset >> log2(GROUP_BITS)); the defaults are 16 entries per frame and 32 bits per group.
- R2: A returned map tag of 0 produces a result with critical = 0 and region = 0.
- R3: A returned tag from 1 to 16 produces a result with critical = 1 and region equal to the tag, whichever location it came from.
- R4: A report whose kind has bit 1 set (2'b10 or 2'b11, multi-bit) is classified on the local path as critical with region 5'h1F. No memory request is made for it. Kinds 2'b00 and 2'b01 are looked up.
- R5: A report that arrives while a lookup or host hand-off is under way waits in a one-deep slot and is processed after it, in arrival order. A report that arrives in the same cycle the slot is drained is also kept.
- R6: A report that arrives while the slot is full and not being drained is discarded and never produces a result, request or interrupt. The overflow output then rises and stays high until reset.
- R7: On the remote path no memory request and no result pulse are produced. The interrupt rises and the host outputs carry the report's frame, offset and kind.
- R8: The interrupt and the host outputs hold until host_ack is sampled high. The interrupt is low in the following cycle, and a waiting report is then handed over in the cycle after that.
- R9: After reset, res_valid, res_critical, res_region, mem_req_valid, irq and overflow are all 0.
- R10: res_critical and res_region keep their values between result pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rep_valid | input | 1 | Error report present this cycle |
| rep_frame | input | FRAME_W | Frame number of the upset |
| rep_offset | input | OFS_W | Bit offset inside the frame |
| rep_kind | input | 2 | Error kind: 00 single, 01 adjacent pair, 1x multi-bit |
| remote_mode | input | 1 | 1 selects host hand-off, 0 selects local lookup |
| mem_req_valid | output | 1 | Map read request, one cycle |
| mem_req_addr | output | ADDR_W | Map entry address |
| mem_rsp_valid | input | 1 | Map read data valid |
| mem_rsp_tag | input | 5 | Region tag read from the map |
| res_valid | output | 1 | Classification result pulse |
| res_critical | output | 1 | Upset is critical |
| res_region | output | 5 | Region tag of the upset (5'h1F if unknown) |
| irq | output | 1 | Host interrupt request |
| host_ack | input | 1 | Host acknowledge |
| host_frame | output | FRAME_W | Cached frame for the host |
| host_offset | output | OFS_W | Cached offset for the host |
| host_kind | output | 2 | Cached error kind for the host |
| overflow | output | 1 | Sticky lost-report flag |

## Verification
Two events can fall on the same clock edge. In the first, a new report arrives in the cycle the holding slot is drained into the engine. In the second, a third report arrives while the slot is still occupied. The bench provokes both by driving three reports on consecutive cycles behind a two-cycle memory. The scoreboard must then see results for the first two only, in order, with overflow set and no request for the third. A memory model compares every request address against the queue of expected addresses, and any request or result pulse that the scoreboard does not expect is counted as a failure.

// File: rtl/upc_pkg.sv
package upc_pkg;

    localparam int REGION_W = 5;
    localparam logic [REGION_W-1:0] REGION_UNKNOWN = 5'h1F;

    typedef enum logic [1:0] {
        KIND_SINGLE  = 2'b00,
        KIND_ADJ     = 2'b01,
        KIND_MULTI   = 2'b10,
        KIND_MULTI_X = 2'b11
    } err_kind_e;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_LOOKUP,
        ENG_HOST
    } eng_state_e;

    typedef struct packed {
        logic                critical;
        logic [REGION_W-1:0] region;
    } verdict_t;

    function automatic logic kind_is_multi(input err_kind_e k);
        return (k == KIND_MULTI) || (k == KIND_MULTI_X);
    endfunction

    function automatic verdict_t tag_to_verdict(input logic [REGION_W-1:0] tag);
        verdict_t v;
        v.critical = (tag != '0);
        v.region   = tag;
        return v;
    endfunction

endpackage

// File: rtl/upc_intake.sv
module upc_intake #(
    parameter int FRAME_W = 6,
    parameter int OFS_W   = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [FRAME_W-1:0] in_frame,
    input  logic [OFS_W-1:0]   in_offset,
    input  upc_pkg::err_kind_e in_kind,
    input  logic               take,
    output logic               slot_valid,
    output logic [FRAME_W-1:0] slot_frame,
    output logic [OFS_W-1:0]   slot_offset,
    output upc_pkg::err_kind_e slot_kind,
    output logic               overflow
);
    import upc_pkg::*;

    logic slot_full_blocked;
    assign slot_full_blocked = slot_valid && !take;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_valid  <= 1'b0;
            slot_frame  <= '0;
            slot_offset <= '0;
            slot_kind   <= KIND_SINGLE;
            overflow    <= 1'b0;
        end else if (in_valid) begin
            if (slot_full_blocked) begin
                overflow <= 1'b1;
            end else begin
                slot_valid  <= 1'b1;
                slot_frame  <= in_frame;
                slot_offset <= in_offset;
                slot_kind   <= in_kind;
            end
        end else if (take) begin
            slot_valid <= 1'b0;
        end
    end

    // R6: once a report is lost the flag never falls before reset
    assert_overflow_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    // R5: a drained slot with no new arrival becomes empty
    assert_slot_drains_R5: assert property (@(posedge clk) disable iff (rst)
        (take && !in_valid) |=> !slot_valid);

endmodule

// File: rtl/upc_engine.sv
module upc_engine #(
    parameter int FRAME_W         = 6,
    parameter int OFS_W           = 9,
    parameter int WORDS_PER_FRAME = 16,
    parameter int GROUP_BITS      = 32,
    parameter int ADDR_W          = 10
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         remote_mode,
    input  logic                         slot_valid,
    input  logic [FRAME_W-1:0]           slot_frame,
    input  logic [OFS_W-1:0]             slot_offset,
    input  upc_pkg::err_kind_e           slot_kind,
    input  logic                         host_ack,
    output logic                         take,
    output logic                         host_load,
    output logic                         mem_req_valid,
    output logic [ADDR_W-1:0]            mem_req_addr,
    input  logic                         mem_rsp_valid,
    input  logic [upc_pkg::REGION_W-1:0] mem_rsp_tag,
    output logic                         res_valid,
    output upc_pkg::verdict_t            res
);
    import upc_pkg::*;

    localparam int GROUP_SHIFT = $clog2(GROUP_BITS);

    eng_state_e       state;
    logic [ADDR_W-1:0] entry_addr;

    assign take      = (state == ENG_IDLE) && slot_valid;
    assign host_load = take && remote_mode;

    assign entry_addr = ADDR_W'(slot_frame) * ADDR_W'(WORDS_PER_FRAME)
                      + ADDR_W'(slot_offset >> GROUP_SHIFT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ENG_IDLE;
            mem_req_valid <= 1'b0;
            mem_req_addr  <= '0;
            res_valid     <= 1'b0;
            res           <= '0;
        end else begin
            mem_req_valid <= 1'b0;
            res_valid     <= 1'b0;
            unique case (state)
                ENG_IDLE: begin
                    if (slot_valid) begin
                        if (remote_mode) begin
                            state <= ENG_HOST;
                        end else if (kind_is_multi(slot_kind)) begin
                            res_valid    <= 1'b1;
                            res.critical <= 1'b1;
                            res.region   <= REGION_UNKNOWN;
                        end else begin
                            mem_req_valid <= 1'b1;
                            mem_req_addr  <= entry_addr;
                            state         <= ENG_LOOKUP;
                        end
                    end
                end
                ENG_LOOKUP: begin
                    if (mem_rsp_valid) begin
                        res_valid <= 1'b1;
                        res       <= tag_to_verdict(mem_rsp_tag);
                        state     <= ENG_IDLE;
                    end
                end
                ENG_HOST: begin
                    if (host_ack) begin
                        state <= ENG_IDLE;
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // R1: a request never lasts longer than one cycle
    assert_req_single_cycle_R1: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid);

    // R2: a non-critical result always carries region 0
    assert_noncrit_region_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res.critical) |-> (res.region == '0));

    // R7: no memory traffic or result while a report is with the host
    assert_host_no_mem_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ENG_HOST) |=> !mem_req_valid && !res_valid);

    // R10: result fields only move together with a result pulse
    assert_result_held_R10: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> $stable(res));

endmodule

// File: rtl/upc_host_cache.sv
module upc_host_cache #(
    parameter int FRAME_W = 6,
    parameter int OFS_W   = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] in_frame,
    input  logic [OFS_W-1:0]   in_offset,
    input  upc_pkg::err_kind_e in_kind,
    input  logic               host_ack,
    output logic               irq,
    output logic [FRAME_W-1:0] host_frame,
    output logic [OFS_W-1:0]   host_offset,
    output upc_pkg::err_kind_e host_kind
);
    import upc_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq         <= 1'b0;
            host_frame  <= '0;
            host_offset <= '0;
            host_kind   <= KIND_SINGLE;
        end else if (load) begin
            irq         <= 1'b1;
            host_frame  <= in_frame;
            host_offset <= in_offset;
            host_kind   <= in_kind;
        end else if (host_ack) begin
            irq <= 1'b0;
        end
    end

    // R8: the interrupt is held until the host acknowledges
    assert_irq_held_R8: assert property (@(posedge clk) disable iff (rst)
        (irq && !host_ack) |=> irq);

    // R8: an acknowledge drops the interrupt on the next cycle
    assert_irq_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (irq && host_ack) |=> !irq);

    // R7: cached report fields stay put while the host owns them
    assert_cache_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (irq && !load) |=> $stable(host_frame) && $stable(host_offset));

endmodule

// File: rtl/upset_classifier.sv
module upset_classifier #(
    parameter  int FRAME_W         = 6,
    parameter  int OFS_W           = 9,
    parameter  int WORDS_PER_FRAME = 16,
    parameter  int GROUP_BITS      = 32,
    localparam int ADDR_W          = FRAME_W + $clog2(WORDS_PER_FRAME)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rep_valid,
    input  logic [FRAME_W-1:0] rep_frame,
    input  logic [OFS_W-1:0]   rep_offset,
    input  logic [1:0]         rep_kind,
    input  logic               remote_mode,
    output logic               mem_req_valid,
    output logic [ADDR_W-1:0]  mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [4:0]         mem_rsp_tag,
    output logic               res_valid,
    output logic               res_critical,
    output logic [4:0]         res_region,
    output logic               irq,
    input  logic               host_ack,
    output logic [FRAME_W-1:0] host_frame,
    output logic [OFS_W-1:0]   host_offset,
    output logic [1:0]         host_kind,
    output logic               overflow
);
    import upc_pkg::*;

    logic               slot_valid;
    logic [FRAME_W-1:0] slot_frame;
    logic [OFS_W-1:0]   slot_offset;
    err_kind_e          slot_kind;
    err_kind_e          cached_kind;
    logic               take;
    logic               host_load;
    verdict_t           verdict;

    upc_intake #(.FRAME_W(FRAME_W), .OFS_W(OFS_W)) u_intake (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (rep_valid),
        .in_frame   (rep_frame),
        .in_offset  (rep_offset),
        .in_kind    (err_kind_e'(rep_kind)),
        .take       (take),
        .slot_valid (slot_valid),
        .slot_frame (slot_frame),
        .slot_offset(slot_offset),
        .slot_kind  (slot_kind),
        .overflow   (overflow)
    );

    upc_engine #(
        .FRAME_W        (FRAME_W),
        .OFS_W          (OFS_W),
        .WORDS_PER_FRAME(WORDS_PER_FRAME),
        .GROUP_BITS     (GROUP_BITS),
        .ADDR_W         (ADDR_W)
    ) u_engine (
        .clk          (clk),
        .rst          (rst),
        .remote_mode  (remote_mode),
        .slot_valid   (slot_valid),
        .slot_frame   (slot_frame),
        .slot_offset  (slot_offset),
        .slot_kind    (slot_kind),
        .host_ack     (host_ack),
        .take         (take),
        .host_load    (host_load),
        .mem_req_valid(mem_req_valid),
        .mem_req_addr (mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_tag  (mem_rsp_tag),
        .res_valid    (res_valid),
        .res          (verdict)
    );

    upc_host_cache #(.FRAME_W(FRAME_W), .OFS_W(OFS_W)) u_cache (
        .clk        (clk),
        .rst        (rst),
        .load       (host_load),
        .in_frame   (slot_frame),
        .in_offset  (slot_offset),
        .in_kind    (slot_kind),
        .host_ack   (host_ack),
        .irq        (irq),
        .host_frame (host_frame),
        .host_offset(host_offset),
        .host_kind  (cached_kind)
    );

    assign res_critical = verdict.critical;
    assign res_region   = verdict.region;
    assign host_kind    = cached_kind;

    // R9: nothing is signalled in the first cycle after reset
    assert_reset_quiet_R9: assert property (@(posedge clk)
        $past(rst) |-> !res_valid && !mem_req_valid && !irq && !overflow);

endmodule

// File: tb/tb_upset_classifier.sv
module tb_upset_classifier;

    localparam int FW  = 6;
    localparam int OW  = 9;
    localparam int AW  = 10;
    localparam int LAT = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rep_valid = 1'b0;
    logic [FW-1:0] rep_frame = '0;
    logic [OW-1:0] rep_offset = '0;
    logic [1:0]    rep_kind = 2'b00;
    logic          remote_mode = 1'b0;
    logic          mem_req_valid;
    logic [AW-1:0] mem_req_addr;
    logic          mem_rsp_valid = 1'b0;
    logic [4:0]    mem_rsp_tag = '0;
    logic          res_valid, res_critical;
    logic [4:0]    res_region;
    logic          irq;
    logic          host_ack = 1'b0;
    logic [FW-1:0] host_frame;
    logic [OW-1:0] host_offset;
    logic [1:0]    host_kind;
    logic          overflow;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [5:0]    expq[$];
    logic [AW-1:0] addrq[$];
    logic [5:0]    last_exp = '0;

    always #4 clk = ~clk;

    upset_classifier dut (
        .clk(clk), .rst(rst), .rep_valid(rep_valid), .rep_frame(rep_frame),
        .rep_offset(rep_offset), .rep_kind(rep_kind), .remote_mode(remote_mode),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag),
        .res_valid(res_valid), .res_critical(res_critical), .res_region(res_region),
        .irq(irq), .host_ack(host_ack), .host_frame(host_frame),
        .host_offset(host_offset), .host_kind(host_kind), .overflow(overflow)
    );

    function automatic logic [4:0] map_tag(input int addr);
        return 5'(addr % 17);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // memory model: compares request addresses, answers after LAT cycles
    int          rsp_cnt = 0;
    logic [4:0]  rsp_hold = '0;
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (rsp_cnt > 0) begin
            rsp_cnt--;
            if (rsp_cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_tag   = rsp_hold;
            end
        end
        if (!rst && mem_req_valid) begin
            if (addrq.size() == 0) begin
                check(1'b0, "R1 unexpected request", int'(mem_req_addr), -1);
            end else begin
                logic [AW-1:0] ea;
                ea = addrq.pop_front();
                check(mem_req_addr == ea, "R1 request address", int'(mem_req_addr), int'(ea));
            end
            rsp_hold = map_tag(int'(mem_req_addr));
            rsp_cnt  = LAT;
        end
    end

    // monitor: pops expected verdicts on every result pulse
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (expq.size() == 0) begin
                check(1'b0, "R6/R7 unexpected result", int'({res_critical, res_region}), -1);
            end else begin
                logic [5:0] e;
                e = expq.pop_front();
                check({res_critical, res_region} == e, "R2/R3/R4 verdict",
                      int'({res_critical, res_region}), int'(e));
            end
        end
    end

    // driver: one report for one cycle, starting at a falling edge
    task automatic put(input int f, input int o, input int k, input bit expect_out);
        rep_frame  = FW'(f);
        rep_offset = OW'(o);
        rep_kind   = 2'(k);
        rep_valid  = 1'b1;
        if (expect_out && !remote_mode) begin
            logic [5:0] e;
            if (k[1]) begin
                e = {1'b1, 5'h1F};
            end else begin
                int a;
                logic [4:0] t;
                a = f * 16 + (o >> 5);
                addrq.push_back(AW'(a));
                t = map_tag(a);
                e = {t != 0, t};
            end
            expq.push_back(e);
            last_exp = e;
        end
        @(negedge clk);
        rep_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (12) @(negedge clk);
        check(expq.size() == 0, "R5 all results delivered", expq.size(), 0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R9 reset state
        check(!res_valid && !mem_req_valid, "R9 reset valid outputs", int'({res_valid, mem_req_valid}), 0);
        check(!res_critical && res_region == 0, "R9 reset result", int'({res_critical, res_region}), 0);
        check(!irq && !overflow, "R9 reset irq/overflow", int'({irq, overflow}), 0);

        // R2: tag 0 at addr 34, R3: tags 1 and 16
        put(2, 64, 0, 1'b1);  drain();
        put(0, 32, 1, 1'b1);  drain();
        put(1, 0, 0, 1'b1);   drain();
        put(5, 200, 0, 1'b1); drain();
        put(3, 100, 1, 1'b1); drain();
        // R4: multi-bit kinds skip the lookup
        put(7, 5, 2, 1'b1);   drain();
        put(9, 400, 3, 1'b1); drain();
        // R3 then R10: region 16 result held
        put(10, 300, 0, 1'b1); drain();
        check({res_critical, res_region} == last_exp, "R10 result held",
              int'({res_critical, res_region}), int'(last_exp));

        // R5: back-to-back reports, second arrives on the drain cycle
        put(4, 33, 0, 1'b1);
        put(6, 480, 1, 1'b1);
        drain();
        check(!overflow, "R5 no overflow for two reports", int'(overflow), 0);

        // R6: third report hits a full slot and is lost
        put(8, 70, 0, 1'b1);
        put(12, 10, 2, 1'b1);
        put(20, 20, 0, 1'b0);
        drain();
        check(overflow, "R6 overflow set", int'(overflow), 1);
        repeat (5) @(negedge clk);
        check(overflow, "R6 overflow sticky", int'(overflow), 1);
        do_reset();
        check(!overflow, "R9 overflow cleared by reset", int'(overflow), 0);

        // R7/R8: remote hand-off
        remote_mode = 1'b1;
        put(11, 257, 1, 1'b0);
        put(13, 6, 2, 1'b0);
        repeat (2) @(negedge clk);
        check(irq, "R7 irq raised", int'(irq), 1);
        check(host_frame == 11 && host_offset == 257, "R7 host location",
              int'({host_frame, host_offset}), int'({6'd11, 9'd257}));
        check(host_kind == 2'b01, "R7 host kind", int'(host_kind), 1);
        repeat (6) @(negedge clk);
        check(irq && host_frame == 11, "R8 irq and cache held", int'({irq, host_frame}), int'({1'b1, 6'd11}));
        host_ack = 1'b1;
        @(negedge clk);
        host_ack = 1'b0;
        check(!irq, "R8 irq drops after ack", int'(irq), 0);
        @(negedge clk);
        check(irq && host_frame == 13 && host_offset == 6 && host_kind == 2'b10,
              "R8 waiting report handed over", int'({irq, host_frame}), int'({1'b1, 6'd13}));
        host_ack = 1'b1;
        @(negedge clk);
        host_ack = 1'b0;
        repeat (4) @(negedge clk);
        check(!irq && !overflow, "R8 idle after second ack", int'({irq, overflow}), 0);
        remote_mode = 1'b0;

        // back to local after remote
        put(1, 511, 0, 1'b1);
        drain();
        check(addrq.size() == 0, "R1 no stray requests", addrq.size(), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule